// File: doc/BRIEF.md
# Shared-Generator PWM Controller

This block drives a large set of output channels from a small pool of waveform generators. Each generator holds a period, counted in coarse ticks, and a duty value that sets the fraction of that period spent high. Every channel has a small map entry that either switches the channel off or names the generator whose waveform it copies. Many channels can therefore blink or dim in lock-step while storing only a few bits each.

Software configures the block through a word-wide register port with one write strobe and a combinational read path. Generator settings are double-buffered: a write lands in a staging copy, and the running generator picks it up only when its current period ends. The channel outputs are registered and split into two groups. The low channels drive pins directly, and the remaining channels form a parallel word that a separate serial-expander block shifts out.

Timing is built from a step, which is 1/255 of a tick. A prescaler derives the step from the system clock. Its divide value is a parameter, so a real tick (for example 4 ms) and a fast simulation setting use the same logic.

Top module: `spwm_ctrl`

## Requirements
- R1: After reset, every channel output is 0. Every period field reads 1, and every duty field, spare byte and map entry reads 0.
- R2: The register words are decoded as follows (default sizes).
  - Words 0–1 hold periods, four generators per word in 8-bit lanes, with generator g at bits 8*(g%4) upward.
  - Words 2–5 hold duties, two generators per word at 16-bit spacing: duty in bits 7:0 of each half and a stored, readable spare byte in bits 15:8.
  - Words 6–10 hold the channel map, eight 4-bit entries per word with channel c at nibble c%8. In each entry, bit 3 enables the channel and bits 2:0 select the generator.
- R3: A period value of 0 is stored as 1, and a value above 250 is stored as 250. Legal values are stored unchanged.
- R4: A generator with period P and duty D repeats every P*255 steps. It is high for the first D*P steps and low for the rest. One step is STEP_DIV clocks.
- R5: All channels mapped to the same generator change level in the same clock cycle.
- R6: A channel whose enable bit is 0 outputs a constant 0, whatever generator it selects.
- R7: Duty 0 gives a constant low and duty 255 gives a constant high, with no pulse at period boundaries.
- R8: A period or duty write takes effect only at the end of the generator's running period. The running period finishes with the old values.
- R9: Channels below NUM_DIRECT appear on pin_o. Channel c at or above NUM_DIRECT appears on exp_o bit c-NUM_DIRECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word index written |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word index read |
| rd_data | output | 32 | Read data (combinational) |
| pin_o | output | NUM_DIRECT | Directly driven channel outputs |
| exp_o | output | NUM_CH-NUM_DIRECT | Channel levels for the serial expander |

## Verification
The bench keeps the default pool of 8 generators, 33 channels and 16 direct pins, so the register layout and the split of channels between the two outputs are the production ones. It sets STEP_DIV to 2 instead of a multi-million clock divide. A two-tick period then lasts 1020 clocks, so whole high and low runs and a deferred reconfiguration fit in a few thousand cycles. A divide above 1 also keeps the prescaler's counting variant in the build.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

   localparam int unsigned PER_MIN   = 1;
   localparam int unsigned PER_MAX   = 250;
   localparam int unsigned DUTY_FULL = 255;
   localparam int unsigned SEL_W     = 3;

   typedef struct packed {
      logic             en;
      logic [SEL_W-1:0] sel;
   } map_ent_t;

   function automatic logic [7:0] clamp_per(input logic [7:0] v);
      if (v == 8'd0)        return 8'(PER_MIN);
      else if (v > 8'd250)  return 8'(PER_MAX);
      else                  return v;
   endfunction

endpackage

// File: rtl/spwm_prescale.sv
module spwm_prescale #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic step_o
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("spwm_prescale: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_pass
         assign step_o = 1'b1;
      end else begin : g_cnt
         localparam int unsigned W = $clog2(DIV);
         logic [W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)                     cnt <= '0;
            else if (cnt == W'(DIV - 1))    cnt <= '0;
            else                            cnt <= cnt + 1'b1;
         end

         assign step_o = (cnt == W'(DIV - 1));

         // R4
         step_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
            step_o |=> !step_o);
      end
   endgenerate

endmodule

// File: rtl/spwm_wavegen.sv
module spwm_wavegen (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step_i,
   input  logic [7:0] per_i,
   input  logic [7:0] duty_i,
   output logic       wave_o
);
   import spwm_pkg::*;

   localparam int unsigned CNT_W = 16;

   logic [7:0]       per_a;
   logic [7:0]       duty_a;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] hi_len;
   logic             wrap;

   assign last   = CNT_W'(per_a) * CNT_W'(DUTY_FULL) - 1'b1;
   assign hi_len = CNT_W'(duty_a) * CNT_W'(per_a);
   assign wrap   = step_i && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_a  <= 8'(PER_MIN);
         duty_a <= 8'd0;
         cnt    <= '0;
      end else if (wrap) begin
         per_a  <= per_i;
         duty_a <= duty_i;
         cnt    <= '0;
      end else if (step_i) begin
         cnt    <= cnt + 1'b1;
      end
   end

   assign wave_o = (cnt < hi_len);

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last);
   // R8
   defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(per_a) && $stable(duty_a)));
   // R7
   full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_a == 8'd255) |-> wave_o);
   // R7
   zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_a == 8'd0) |-> !wave_o);

endmodule

// File: rtl/spwm_regfile.sv
module spwm_regfile #(
   parameter int unsigned NUM_GEN = 8,
   parameter int unsigned NUM_CH  = 33,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [31:0]                       wr_data,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [31:0]                       rd_data,
   output logic [NUM_GEN-1:0][7:0]           per_o,
   output logic [NUM_GEN-1:0][7:0]           duty_o,
   output spwm_pkg::map_ent_t [NUM_CH-1:0]   map_o
);
   import spwm_pkg::*;

   localparam int unsigned PER_REGS  = (NUM_GEN + 3) / 4;
   localparam int unsigned DUTY_REGS = (NUM_GEN + 1) / 2;
   localparam int unsigned MAP_REGS  = (NUM_CH + 7) / 8;
   localparam int unsigned DUTY_BASE = PER_REGS;
   localparam int unsigned MAP_BASE  = DUTY_BASE + DUTY_REGS;
   localparam int unsigned NUM_REGS  = MAP_BASE + MAP_REGS;

   logic [NUM_GEN-1:0][7:0] aux_w;

   generate
      if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
         $error("spwm_regfile: ADDR_W too narrow for the register set");
      end

      for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
         localparam int unsigned PR = g / 4;
         localparam int unsigned PL = g % 4;
         localparam int unsigned DR = DUTY_BASE + g / 2;
         localparam int unsigned DH = g % 2;
         logic [7:0] per_r, duty_r, aux_r;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               per_r  <= 8'(PER_MIN);
               duty_r <= 8'd0;
               aux_r  <= 8'd0;
            end else if (wr_en) begin
               if (wr_addr == ADDR_W'(PR))
                  per_r <= clamp_per(wr_data[8*PL +: 8]);
               if (wr_addr == ADDR_W'(DR)) begin
                  duty_r <= wr_data[16*DH +: 8];
                  aux_r  <= wr_data[16*DH + 8 +: 8];
               end
            end
         end

         assign per_o[g]  = per_r;
         assign duty_o[g] = duty_r;
         assign aux_w[g]  = aux_r;

         // R3
         per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (per_r >= 8'd1) && (per_r <= 8'd250));
      end

      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int unsigned MR = MAP_BASE + c / 8;
         localparam int unsigned MN = c % 8;
         map_ent_t ent_r;

         always_ff @(posedge clk) begin
            if (!rst_n)
               ent_r <= '0;
            else if (wr_en && wr_addr == ADDR_W'(MR))
               ent_r <= wr_data[4*MN +: 4];
         end

         assign map_o[c] = ent_r;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int g = 0; g < NUM_GEN; g++) begin
         if (rd_addr == ADDR_W'(g / 4))
            rd_data[8*(g%4) +: 8] = per_o[g];
         if (rd_addr == ADDR_W'(DUTY_BASE + g / 2))
            rd_data[16*(g%2) +: 16] = {aux_w[g], duty_o[g]};
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_addr == ADDR_W'(MAP_BASE + c / 8))
            rd_data[4*(c%8) +: 4] = map_o[c];
      end
   end

endmodule

// File: rtl/spwm_ctrl.sv
module spwm_ctrl #(
   parameter int unsigned NUM_GEN    = 8,
   parameter int unsigned NUM_CH     = 33,
   parameter int unsigned NUM_DIRECT = 16,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned STEP_DIV   = 1960784
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [31:0]                  wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [31:0]                  rd_data,
   output logic [NUM_DIRECT-1:0]        pin_o,
   output logic [NUM_CH-NUM_DIRECT-1:0] exp_o
);
   import spwm_pkg::*;

   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   logic                      step;
   logic [NUM_GEN-1:0][7:0]   per_w;
   logic [NUM_GEN-1:0][7:0]   duty_w;
   map_ent_t [NUM_CH-1:0]     map_w;
   logic [NUM_GEN-1:0]        wave;
   logic [SEL_SPAN-1:0]       wave_pad;
   logic [NUM_CH-1:0]         ch_d;
   logic [NUM_CH-1:0]         ch_q;

   generate
      if (NUM_GEN < 1 || NUM_GEN > SEL_SPAN) begin : g_bad_gen
         $error("spwm_ctrl: NUM_GEN out of range for the select field");
      end
      if (NUM_DIRECT < 1 || NUM_DIRECT >= NUM_CH) begin : g_bad_split
         $error("spwm_ctrl: NUM_DIRECT must leave at least one expander channel");
      end
   endgenerate

   spwm_prescale #(.DIV(STEP_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_o (step)
   );

   spwm_regfile #(
      .NUM_GEN (NUM_GEN),
      .NUM_CH  (NUM_CH),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .per_o   (per_w),
      .duty_o  (duty_w),
      .map_o   (map_w)
   );

   generate
      for (genvar g = 0; g < NUM_GEN; g++) begin : g_wave
         spwm_wavegen u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_i (step),
            .per_i  (per_w[g]),
            .duty_i (duty_w[g]),
            .wave_o (wave[g])
         );
      end
   endgenerate

   assign wave_pad = SEL_SPAN'(wave);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
         assign ch_d[c] = map_w[c].en && wave_pad[map_w[c].sel];

         // R6
         off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !map_w[c].en |=> !ch_q[c]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ch_q <= '0;
      else        ch_q <= ch_d;
   end

   assign pin_o = ch_q[NUM_DIRECT-1:0];
   assign exp_o = ch_q[NUM_CH-1:NUM_DIRECT];

endmodule

// File: tb/spwm_ctrl_tb.sv
module spwm_ctrl_tb;

   localparam int unsigned NG = 8, NC = 33, ND = 16, AW = 4, DIV = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic [ND-1:0] pin_o;
   logic [NC-ND-1:0] exp_o;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct { bit lvl; int len; string tag; } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   spwm_ctrl #(
      .NUM_GEN(NG), .NUM_CH(NC), .NUM_DIRECT(ND), .ADDR_W(AW), .STEP_DIV(DIV)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_o(pin_o), .exp_o(exp_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input int a, output logic [31:0] d);
      rd_addr = AW'(a);
      #1;
      d = rd_data;
   endtask

   task automatic push(input bit lvl, input int len, input string tag);
      exp_t e;
      e.lvl = lvl; e.len = len; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: measures complete runs on channel 0 and compares them with the queue.
   bit prev_lvl = 1'b0;
   bit run_ok = 1'b0;
   int run_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pin_o[0] !== prev_lvl) begin
            if (run_ok && exp_q.size() > 0) begin
               exp_t e;
               e = exp_q.pop_front();
               n_chk++;
               if (prev_lvl !== e.lvl || run_len != e.len) begin
                  n_bad++;
                  $display("FAIL %s: actual level %0d for %0d clocks expected level %0d for %0d clocks",
                           e.tag, prev_lvl, run_len, e.lvl, e.len);
               end
            end
            run_ok = (exp_q.size() > 0);
            run_len = 1;
            prev_lvl = pin_o[0];
         end else begin
            run_len++;
         end
      end
   end

   // R5 / R9: channels sharing generator 3 must track channel 0 exactly.
   bit share_mon = 1'b0;
   int share_err = 0;
   always @(negedge clk) begin
      if (share_mon && (pin_o[5] !== pin_o[0] || exp_o[4] !== pin_o[0]))
         share_err++;
   end

   task automatic drain;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int e1, e2, e6, ex;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R1 outputs low", 32'({exp_o, pin_o}), 32'h0);
      reg_rd(0, d); chk("R1 period reset", d, 32'h01010101);
      reg_rd(2, d); chk("R1 duty reset", d, 32'h0);
      reg_rd(6, d); chk("R1 map reset", d, 32'h0);

      // R3: lanes g4=250, g5=7, g6=0, g7=255
      reg_wr(1, 32'hFF0007FA);
      reg_rd(1, d); chk("R3 period clamp", d, 32'hFA0107FA);

      // R2: g1 per 3, g2 per 1, g3 per 2
      reg_wr(0, 32'h02010301);
      reg_rd(0, d); chk("R2 period lanes", d, 32'h02010301);
      // g0 spare 0x5A, g1 duty 255
      reg_wr(2, 32'h00FF5A00);
      reg_rd(2, d); chk("R2 duty and spare", d, 32'h00FF5A00);
      // g2 duty 0, g3 duty 100
      reg_wr(3, 32'h00640000);
      // ch0->g3, ch1->g1, ch2->g2, ch5->g3, ch6 disabled (sel g1)
      reg_wr(6, 32'h01B00A9B);
      reg_rd(6, d); chk("R2 map nibbles", d, 32'h01B00A9B);
      // ch20 -> g3
      reg_wr(8, 32'h000B0000);
      reg_rd(8, d); chk("R2 map upper word", d, 32'h000B0000);

      repeat (1200) @(negedge clk);
      share_mon = 1'b1;

      // R4: period 2 ticks, duty 100 -> high 200 steps, period 510 steps, 2 clocks per step
      while (!pin_o[0]) @(negedge clk);
      repeat (50) @(negedge clk);
      push(1'b0, 620, "R4 low run");
      push(1'b1, 400, "R4 high run");
      push(1'b0, 620, "R4 low run");
      drain();
      share_mon = 1'b0;
      chk("R5 shared channels aligned", 32'(share_err), 32'h0);

      // R6 / R7 / R9 over a window longer than any configured period
      e1 = 0; e2 = 0; e6 = 0; ex = 0;
      for (int i = 0; i < 1600; i++) begin
         @(negedge clk);
         if (pin_o[1] !== 1'b1) e1++;
         if (pin_o[2] !== 1'b0) e2++;
         if (pin_o[6] !== 1'b0) e6++;
         if ((exp_o & ~17'h00010) !== 17'h0) ex++;
      end
      chk("R7 duty full constant high", 32'(e1), 32'h0);
      chk("R7 duty zero constant low", 32'(e2), 32'h0);
      chk("R6 disabled channel low", 32'(e6), 32'h0);
      chk("R9 unmapped expander bits low", 32'(ex), 32'h0);

      // R8: change duty to 50 in the middle of a high phase
      while (!pin_o[0]) @(negedge clk);
      repeat (50) @(negedge clk);
      push(1'b0, 620, "R8 old low completes");
      push(1'b1, 200, "R8 new high");
      push(1'b0, 820, "R8 new low");
      reg_wr(3, 32'h00320000);
      drain();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule